// File: doc/BRIEF.md
# Strobe-Framed Serial Register Slave

This block sits on the device end of a three-wire serial link that has a separate strobe line. Through it a host reaches a small bank of 32-bit control and status registers. The host owns the serial clock, the serial data input and an active-low strobe. The block answers on a single serial data output. All three host pins are brought into the system clock domain through synchronizer chains. Serial clock edges are found there, so the system clock must run at least four times faster than the serial clock.

A frame has no select window. Bits shift in on every serial clock rising edge while the strobe is high. A single rising edge taken while the strobe is low is the command edge. The data-in level captured on that edge selects a read or a write, and the edge closes the frame. A write sends its data word first and its address last. A read sends only the address, and the block then returns the addressed word over the following 32 serial clocks.

The register bank holds two control words that drive output ports and a reset word. Writing the reset word with bit 0 set gives a one-cycle reset-request pulse. The bank also has a read-only input port for switch status and a read-only version constant.

Top module: `strobe_reg_slave`

## Requirements
- R1: At the command edge the data-in level is the command: 1 means write, 0 means read. For a write, the 40 bits shifted most recently are split so that the first 32 bits shifted (MSB first) form the data word and the last 8 bits shifted (MSB first) form the address.
- R2: A read returns the addressed 32-bit word MSB first. The MSB appears on `ser_dout_o` once the falling edge of the command clock has been seen. Each following bit appears after the next falling edge, so the host can sample one bit just as it raises each of the 32 read clocks. Between these falling edges `ser_dout_o` does not change.
- R3: Bits shifted before the last 40 have no effect. A write preceded by extra leading bits stores the same word it would store without them.
- R4: Address 0x00 is the mode word and address 0x02 is the mux word. Both can be read and written, and their contents drive `mode_o` and `mux_o`.
- R5: Address 0xFF reads the `VERSION` parameter. Writes to it change nothing.
- R6: Address 0x08 reads `switch_i` as sampled at the command edge. Writes to it change nothing.
- R7: Address 0x80 is the reset word. It reads back the last value written. A write with bit 0 = 1 gives exactly one `rst_req_o` pulse one system clock wide. A write with bit 0 = 0 gives no pulse.
- R8: A write to any other address leaves every register unchanged. A read of any other address returns zero.
- R9: After reset, `mode_o`, `mux_o`, `rst_req_o` and `ser_dout_o` are 0. Rising edges taken while the strobe is high never change a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from host, idles low |
| ser_din_i | input | 1 | Serial data from host |
| ser_stb_n_i | input | 1 | Active-low strobe from host, idles high |
| ser_dout_o | output | 1 | Serial read data to host |
| switch_i | input | DATA_W | Switch status word, readable at 0x08 |
| mode_o | output | DATA_W | Mode word contents |
| mux_o | output | DATA_W | Mux word contents |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The main function is tried with write frames that carry alternating, walking and all-ones data. Each is followed by a read-back, which separates a correct data/address split from one that is off by a bit or reversed. Frames with extra leading bits are compared with the same frames sent clean, to show that only the last 40 bits count. Strobe-high clock bursts that imitate a full frame show that nothing is written without the command edge. Reads and writes of every mapped address, and of an unmapped one, separate the read-only, read/write and ignored cases. Reset-word writes with bit 0 set and with bit 0 clear show the difference between pulse and no pulse.

// File: rtl/srs_pkg.sv
package srs_pkg;
   typedef enum logic {
      SRS_CMD_READ  = 1'b0,
      SRS_CMD_WRITE = 1'b1
   } srs_cmd_e;

   function automatic logic srs_addr_hit(input logic [7:0] a, input logic [7:0] b);
      return a == b;
   endfunction
endpackage

// File: rtl/srs_sync_edge.sv
module srs_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_raw,
   input  logic din_raw,
   input  logic stb_n_raw,
   output logic din_s,
   output logic stb_n_s,
   output logic sclk_rise,
   output logic sclk_fall
);
   localparam int NSIG = 3;
   localparam logic [NSIG-1:0] IDLE = 3'b100; // strobe idles high

   logic [NSIG-1:0] raw;
   logic [NSIG-1:0] chain [STAGES];
   logic            sclk_d_q;

   assign raw = {stb_n_raw, din_raw, sclk_raw};

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= IDLE;
            else        chain[0] <= raw;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= IDLE;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d_q <= 1'b0;
      else        sclk_d_q <= chain[STAGES-1][0];
   end

   assign din_s     = chain[STAGES-1][1];
   assign stb_n_s   = chain[STAGES-1][2];
   assign sclk_rise = chain[STAGES-1][0] & ~sclk_d_q;
   assign sclk_fall = ~chain[STAGES-1][0] & sclk_d_q;

   assert_edges_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_rise |=> !sclk_rise);
endmodule

// File: rtl/srs_frame.sv
module srs_frame
   import srs_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din_s,
   input  logic              stb_n_s,
   input  logic              sclk_rise,
   output logic              cmd_v,
   output srs_cmd_e          cmd_kind,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data
);
   localparam int SHW = ADDR_W + DATA_W;

   logic [SHW-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q     <= '0;
         cmd_v    <= 1'b0;
         cmd_kind <= SRS_CMD_READ;
         cmd_addr <= '0;
         cmd_data <= '0;
      end else begin
         cmd_v <= 1'b0;
         if (sclk_rise) begin
            if (!stb_n_s) begin
               cmd_v    <= 1'b1;
               cmd_kind <= srs_cmd_e'(din_s);
               cmd_addr <= sh_q[ADDR_W-1:0];
               cmd_data <= sh_q[SHW-1:ADDR_W];
            end else begin
               sh_q <= {sh_q[SHW-2:0], din_s};
            end
         end
      end
   end

   assert_cmd_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_v |=> !cmd_v);
endmodule

// File: rtl/srs_regbank.sv
module srs_regbank
   import srs_pkg::*;
#(
   parameter int              ADDR_W    = 8,
   parameter int              DATA_W    = 32,
   parameter logic [ADDR_W-1:0] A_MODE  = 8'h00,
   parameter logic [ADDR_W-1:0] A_MUX   = 8'h02,
   parameter logic [ADDR_W-1:0] A_SW    = 8'h08,
   parameter logic [ADDR_W-1:0] A_RST   = 8'h80,
   parameter logic [ADDR_W-1:0] A_VER   = 8'hFF,
   parameter logic [DATA_W-1:0] VERSION = 32'h0001_0203
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_v,
   input  srs_cmd_e          cmd_kind,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic [DATA_W-1:0] switch_i,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] mode_q,
   output logic [DATA_W-1:0] mux_q,
   output logic              rst_req_q
);
   logic [DATA_W-1:0] rstv_q;
   logic              wr;

   assign wr = cmd_v && (cmd_kind == SRS_CMD_WRITE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= '0;
         mux_q     <= '0;
         rstv_q    <= '0;
         rst_req_q <= 1'b0;
      end else begin
         rst_req_q <= 1'b0;
         if (wr) begin
            unique case (cmd_addr)
               A_MODE: mode_q <= cmd_data;
               A_MUX:  mux_q  <= cmd_data;
               A_RST: begin
                  rstv_q    <= cmd_data;
                  rst_req_q <= cmd_data[0];
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (cmd_addr == A_MODE) rd_data = mode_q;
      if (cmd_addr == A_MUX)  rd_data = mux_q;
      if (cmd_addr == A_SW)   rd_data = switch_i;
      if (cmd_addr == A_RST)  rd_data = rstv_q;
      if (cmd_addr == A_VER)  rd_data = VERSION;
   end

   assert_pulse_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_q |=> !rst_req_q);
   assert_pulse_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_q |-> rstv_q[0]);
endmodule

// File: rtl/srs_readout.sv
module srs_readout
   import srs_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_v,
   input  srs_cmd_e          cmd_kind,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              sclk_fall,
   output logic              dout
);
   logic [DATA_W-1:0] hold_q, out_q;
   logic              pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         out_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         if (cmd_v && cmd_kind == SRS_CMD_READ) begin
            hold_q <= rd_data;
            pend_q <= 1'b1;
         end
         if (sclk_fall) begin
            if (pend_q) begin
               out_q  <= hold_q;
               pend_q <= 1'b0;
            end else begin
               out_q <= {out_q[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign dout = out_q[DATA_W-1];

   assert_dout_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_fall |=> $stable(dout));
endmodule

// File: rtl/strobe_reg_slave.sv
module strobe_reg_slave
   import srs_pkg::*;
#(
   parameter int                ADDR_W      = 8,
   parameter int                DATA_W      = 32,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] A_MODE      = 8'h00,
   parameter logic [ADDR_W-1:0] A_MUX       = 8'h02,
   parameter logic [ADDR_W-1:0] A_SW        = 8'h08,
   parameter logic [ADDR_W-1:0] A_RST       = 8'h80,
   parameter logic [ADDR_W-1:0] A_VER       = 8'hFF,
   parameter logic [DATA_W-1:0] VERSION     = 32'hC0DE_0107
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_din_i,
   input  logic              ser_stb_n_i,
   output logic              ser_dout_o,
   input  logic [DATA_W-1:0] switch_i,
   output logic [DATA_W-1:0] mode_o,
   output logic [DATA_W-1:0] mux_o,
   output logic              rst_req_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 2) begin : g_bad_width
      $error("ADDR_W must be >= 1 and DATA_W >= 2");
   end
   if (A_MODE == A_MUX || A_MODE == A_SW || A_MODE == A_RST || A_MODE == A_VER ||
       A_MUX == A_SW || A_MUX == A_RST || A_MUX == A_VER ||
       A_SW == A_RST || A_SW == A_VER || A_RST == A_VER) begin : g_bad_map
      $error("register addresses must be distinct");
   end

   logic              din_s, stb_n_s, sclk_rise, sclk_fall;
   logic              cmd_v;
   srs_cmd_e          cmd_kind;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] cmd_data, rd_data;

   srs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .sclk_raw(ser_clk_i), .din_raw(ser_din_i), .stb_n_raw(ser_stb_n_i),
      .din_s(din_s), .stb_n_s(stb_n_s), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall));

   srs_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .din_s(din_s), .stb_n_s(stb_n_s),
      .sclk_rise(sclk_rise), .cmd_v(cmd_v), .cmd_kind(cmd_kind),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data));

   srs_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .A_MODE(A_MODE), .A_MUX(A_MUX),
                 .A_SW(A_SW), .A_RST(A_RST), .A_VER(A_VER), .VERSION(VERSION)) u_regs (
      .clk(clk), .rst_n(rst_n), .cmd_v(cmd_v), .cmd_kind(cmd_kind),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .switch_i(switch_i),
      .rd_data(rd_data), .mode_q(mode_o), .mux_q(mux_o), .rst_req_q(rst_req_o));

   srs_readout #(.DATA_W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n), .cmd_v(cmd_v), .cmd_kind(cmd_kind),
      .rd_data(rd_data), .sclk_fall(sclk_fall), .dout(ser_dout_o));

   assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_v |=> $stable(mode_o));
   assert_mux_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_v |=> $stable(mux_o));
   assert_no_req_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_v && cmd_kind == SRS_CMD_READ) |=> !rst_req_o);
endmodule

// File: tb/sim_strobe_reg_slave.sv
module sim_strobe_reg_slave;
   localparam int HALF = 6;
   localparam logic [31:0] VER = 32'hC0DE_0107;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, din = 1'b0, stb_n = 1'b1;
   logic        dout, rst_req;
   logic [31:0] sw = 32'h0, mode, mux;

   int nchk = 0, nfail = 0;
   int pulses = 0, wide = 0;
   logic req_d = 1'b0;

   logic [31:0] exp_q[$];
   logic [31:0] got_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   strobe_reg_slave u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_din_i(din),
      .ser_stb_n_i(stb_n), .ser_dout_o(dout), .switch_i(sw),
      .mode_o(mode), .mux_o(mux), .rst_req_o(rst_req));

   always @(posedge clk) begin
      req_d <= rst_req;
      if (rst_req) pulses++;
      if (rst_req && req_d) wide++;
   end

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // monitor: pops captured read words against expected scoreboard entries
   initial forever begin
      wait (got_q.size() > 0);
      chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
   end

   task automatic half();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic bit_out(logic b);
      din = b; half(); sclk = 1'b1; half(); sclk = 1'b0;
   endtask

   task automatic command(logic c);
      din = c; stb_n = 1'b0; half();
      sclk = 1'b1; half(); sclk = 1'b0; half();
      stb_n = 1'b1; din = 1'b0;
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      for (int i = 31; i >= 0; i--) bit_out(d[i]);
      for (int i = 7; i >= 0; i--) bit_out(a[i]);
      command(1'b1);
      half();
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
      logic [31:0] w = '0;
      exp_q.push_back(exp); tag_q.push_back(tag);
      for (int i = 7; i >= 0; i--) bit_out(a[i]);
      command(1'b0);
      half();
      for (int i = 0; i < 32; i++) begin
         sclk = 1'b1;
         w = {w[30:0], dout};
         half(); sclk = 1'b0; half();
      end
      got_q.push_back(w);
      half();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog R9 got=timeout exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      int p0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R9 reset state
      chk("R9 mode reset", mode, 0);
      chk("R9 mux reset", mux, 0);
      chk("R9 dout reset", {31'b0, dout}, 0);
      chk("R9 req reset", {31'b0, rst_req}, 0);

      // R1 R4 write and read back with distinct patterns
      wr(8'h00, 32'hA5A5_0F0F);
      chk("R1 mode_o after write", mode, 32'hA5A5_0F0F);
      wr(8'h02, 32'h8000_0001);
      chk("R4 mux_o after write", mux, 32'h8000_0001);
      chk("R4 mode kept", mode, 32'hA5A5_0F0F);
      rd(8'h00, 32'hA5A5_0F0F, "R2 read mode");
      rd(8'h02, 32'h8000_0001, "R4 read mux");
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, 32'hFFFF_FFFF, "R2 all ones");

      // R3 leading junk bits ignored
      for (int i = 0; i < 11; i++) bit_out(i[0]);
      wr(8'h02, 32'h1234_5678);
      chk("R3 junk prefix", mux, 32'h1234_5678);

      // R9 strobe-high clocks look like a frame but write nothing
      for (int i = 31; i >= 0; i--) bit_out(1'b0);
      for (int i = 7; i >= 0; i--) bit_out(1'b0);
      bit_out(1'b1);
      half();
      chk("R9 no command no write", mode, 32'hFFFF_FFFF);

      // R5 version read-only
      rd(8'hFF, VER, "R5 version");
      wr(8'hFF, 32'h0);
      rd(8'hFF, VER, "R5 version after write");

      // R6 switch sampled, read-only
      sw = 32'hDEAD_BEEF;
      rd(8'h08, 32'hDEAD_BEEF, "R6 switch");
      wr(8'h08, 32'h0);
      sw = 32'h0F0F_1234;
      rd(8'h08, 32'h0F0F_1234, "R6 switch after write");

      // R7 reset word
      p0 = pulses;
      wr(8'h80, 32'h0000_0001);
      chk("R7 one pulse", pulses - p0, 1);
      chk("R7 pulse width", wide, 0);
      rd(8'h80, 32'h0000_0001, "R7 readback 1");
      p0 = pulses;
      wr(8'h80, 32'h0000_0002);
      chk("R7 no pulse bit0 clear", pulses - p0, 0);
      rd(8'h80, 32'h0000_0002, "R7 readback 2");

      // R8 unmapped
      wr(8'h05, 32'h5555_AAAA);
      chk("R8 mode unchanged", mode, 32'hFFFF_FFFF);
      chk("R8 mux unchanged", mux, 32'h1234_5678);
      rd(8'h80, 32'h0000_0002, "R8 reset word unchanged");
      rd(8'h05, 32'h0, "R8 unmapped read");

      repeat (20) @(negedge clk);
      chk("R2 scoreboard drained", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule